// File: doc/BRIEF.md
# Five-Function Integer ALU

A purely combinational arithmetic and logic unit for the execute stage of a small load/store processor. Two operand words and a 3-bit operation code go in; a result word, a zero flag and a signed overflow flag come out in the same cycle. The unit covers bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than.

Subtraction and the signed compare share the adder: bit 2 of the operation code inverts the second operand and also feeds the adder carry-in, giving A + ~B + 1. Branch-on-equal logic subtracts and looks at the zero flag. The block has no clock and no handshake, so it sits between pipeline registers owned by the surrounding core.

Top module: `int_alu`

## Requirements
- R1: Operation code 000 drives the result to the bitwise AND of A and B.
- R2: Operation code 001 drives the result to the bitwise OR of A and B.
- R3: Operation code 010 drives the result to A + B modulo 2^32.
- R4: Operation code 110 drives the result to A - B modulo 2^32.
- R5: Operation code 111 drives the result to 1 when A is less than B as signed two's-complement numbers, and to 0 otherwise, bits 31..1 being zero; this holds even when A - B overflows.
- R6: The zero flag is 1 exactly when all 32 result bits are 0, for every operation code; with code 110 it is 1 exactly when A equals B.
- R7: For codes 010 and 110 the overflow flag is 1 exactly when the true signed sum or difference lies outside -2^31 .. 2^31-1.
- R8: For every code other than 010 and 110 the overflow flag is 0.
- R9: The unused codes 011, 100 and 101 drive a result of 0 (so the zero flag reads 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The bench aims at the signed limits: adding two large positives or two large negatives, and subtracting across the sign boundary, where a design taking the overflow from the carry-out would flag unsigned wrap instead. Set-on-less-than is driven with pairs such as the most negative value against 1, where a compare that reads only the difference's sign bit answers backwards. Equal operands under subtraction check that the zero flag spans all bits, and the unused codes check that no stray function or overflow leaks out of the result mux.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  // bit of the operation code that selects invert-and-carry
  localparam int unsigned SUB_BIT = 2;
endpackage

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_out,
  output logic [W-1:0] or_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_out[i] = a[i] & b[i];
    assign or_out[i]  = a[i] | b[i];
  end
endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         neg_b,
  output logic [W-1:0] sum,
  output logic         ovf_raw,
  output logic         less
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   full;

  // neg_b inverts B and supplies the +1 through the carry-in
  assign b_eff = neg_b ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, neg_b};
  assign sum   = full[W-1:0];

  // same-sign inputs producing a different-sign sum
  assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  // sign of the exact difference
  assign less    = sum[MSB] ^ ovf_raw;
endmodule

// File: rtl/int_alu_select.sv
module int_alu_select #(
  parameter int unsigned W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] and_in,
  input  logic [W-1:0] or_in,
  input  logic [W-1:0] sum_in,
  input  logic         less_in,
  input  logic         ovf_in,
  output logic [W-1:0] res,
  output logic         ovf_out
);
  import int_alu_pkg::*;

  always_comb begin
    res     = '0;
    ovf_out = 1'b0;
    case (op)
      OP_AND: res = and_in;
      OP_OR:  res = or_in;
      OP_ADD: begin
        res     = sum_in;
        ovf_out = ovf_in;
      end
      OP_SUB: begin
        res     = sum_in;
        ovf_out = ovf_in;
      end
      OP_SLT: res = {{(W-1){1'b0}}, less_in};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         ovf
);
  import int_alu_pkg::*;

  logic [W-1:0] and_w, or_w, sum_w;
  logic         ovf_w, less_w;

  int_alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .and_out(and_w), .or_out(or_w)
  );

  int_alu_adder #(.W(W)) u_add (
    .a(opnd_a), .b(opnd_b), .neg_b(op_sel[SUB_BIT]),
    .sum(sum_w), .ovf_raw(ovf_w), .less(less_w)
  );

  int_alu_select #(.W(W)) u_sel (
    .op(op_sel), .and_in(and_w), .or_in(or_w), .sum_in(sum_w),
    .less_in(less_w), .ovf_in(ovf_w), .res(result), .ovf_out(ovf)
  );

  assign zero = ~|result;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [2:0]   op_sel,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         ovf
);
  always_comb begin
    // R1: AND result never has a bit that A lacks
    if (op_sel == 3'b000)
      a_r1_and_subset: assert ((result & ~opnd_a) == '0);
    // R2: OR result covers every bit of A
    if (op_sel == 3'b001)
      a_r2_or_cover: assert ((result & opnd_a) == opnd_a);
    // R5: compare yields a single bit, and equal operands give 0
    if (op_sel == 3'b111)
      a_r5_slt_onebit: assert (result[W-1:1] == '0);
    if (op_sel == 3'b111 && opnd_a == opnd_b)
      a_r5_slt_equal: assert (result == '0);
    // R6: equal operands under subtract raise zero without overflow
    if (op_sel == 3'b110 && opnd_a == opnd_b)
      a_r6_eq_zero: assert (zero && !ovf);
    // R8: no overflow outside add and subtract
    if (op_sel != 3'b010 && op_sel != 3'b110)
      a_r8_no_overflow: assert (!ovf);
    // R9: unused codes give a zero result
    if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101)
      a_r9_unused_zero: assert (result == '0 && zero);
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
  .result(result), .zero(zero), .ovf(ovf)
);

// File: tb/sim_int_alu.sv
module sim_int_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  op = 3'b000;
  logic [31:0] result;
  logic        zero, ovf;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  int_alu u0 (.opnd_a(a), .opnd_b(b), .op_sel(op),
              .result(result), .zero(zero), .ovf(ovf));

  function automatic logic [31:0] ref_res(logic [31:0] x, logic [31:0] y, logic [2:0] o);
    case (o)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010: return x + y;
      3'b110: return x - y;
      3'b111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic ref_ovf(logic [31:0] x, logic [31:0] y, logic [2:0] o);
    longint sx, sy, t;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    if (o == 3'b010) t = sx + sy;
    else if (o == 3'b110) t = sx - sy;
    else return 1'b0;
    return (t > 64'sd2147483647) || (t < -64'sd2147483648);
  endfunction

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [2:0] o);
    logic [31:0] er;
    logic        eo;
    @(posedge clk);
    a = x; b = y; op = o;
    @(negedge clk);
    er = ref_res(x, y, o);
    eo = ref_ovf(x, y, o);
    n_chk++;
    if (result !== er) begin
      n_bad++;
      $display("FAIL %s result op=%b a=%h b=%h got=%h exp=%h", req_of(o), o, x, y, result, er);
    end
    n_chk++;
    if (zero !== (er == 32'd0)) begin // R6
      n_bad++;
      $display("FAIL R6 zero op=%b a=%h b=%h got=%b exp=%b", o, x, y, zero, er == 32'd0);
    end
    n_chk++;
    if (ovf !== eo) begin // R7 for add/sub, R8 otherwise
      n_bad++;
      $display("FAIL %s ovf op=%b a=%h b=%h got=%b exp=%b",
               (o == 3'b010 || o == 3'b110) ? "R7" : "R8", o, x, y, ovf, eo);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] ops [8];
    int unsigned seed;
    ops = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b011, 3'b100, 3'b101};
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time vector: zero inputs, AND code
    apply(32'h0, 32'h0, 3'b000);
    // R1/R2 directed
    apply(32'hF0F0_A5A5, 32'hFF00_0F0F, 3'b000);
    apply(32'hF0F0_A5A5, 32'h0F00_0F0F, 3'b001);
    // R3/R7 add overflow corners
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
    apply(32'h8000_0000, 32'h8000_0000, 3'b010);
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010); // carry out, no ovf, zero
    // R4/R7 subtract corners
    apply(32'h8000_0000, 32'h0000_0001, 3'b110);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
    apply(32'h0000_0000, 32'h8000_0000, 3'b110);
    // R6 equality via subtract
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEE, 3'b110);
    // R5 compare incl. overflowing difference
    apply(32'h8000_0000, 32'h0000_0001, 3'b111);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);
    apply(32'h0000_0005, 32'h0000_0005, 3'b111);
    apply(32'h0000_0003, 32'h0000_0004, 3'b111);
    // R9/R8 unused codes with operands that would overflow
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b011);
    apply(32'h8000_0000, 32'h0000_0001, 3'b100);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b101);
    // random mix, with frequent sign-boundary operands
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = $urandom();
      if (($urandom() % 4) == 0) x = {x[31], {31{~x[31]}}};
      if (($urandom() % 8) == 0) y = x;
      apply(x, y, ops[$urandom() % 8]);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule